// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Slave with Selectable Clock Phase and Polarity

This block is the receive/transmit shift engine of a serial peripheral slave. An external master supplies the serial clock, the master-to-slave data line and an active-low select. Each transfer moves one byte in each direction. The block returns the received byte on a parallel output and marks its arrival with a one-cycle strobe. At the same time it shifts a parallel transmit byte out on the slave-to-master line.

The three serial inputs pass through a synchroniser into the system clock domain, and the block detects clock edges there. A polarity input sets the idle level of the serial clock. A phase input sets when a frame starts and which edges sample or shift:

- **Phase 0:** the falling edge of select starts the frame and preloads the MSB. The master must raise select between bytes.
- **Phase 1:** the first clock edge starts the frame, and bytes may follow one another while select stays low.

The data output is meant to feed a pad buffer whose enable is the drive-enable output.

Top module: `spi_shift_slave`

## Requirements
- R1: Bits move most significant first on both data lines, DATA_W (8) bits per byte. The received byte equals the master's byte, and the master gathers the transmit byte unchanged.
- R2: The drive enable `misoOe` is 1 only while select is low. It is 0 within three system cycles after select goes high, and 1 within three cycles after it goes low.
- R3: With phase 0, the MSB of `txByte` appears on `misoOut` after select falls and before the first serial clock edge.
- R4: With phase 0, data is sampled on odd edges (1st, 3rd, ...) and the output advances on even edges.
- R5: With phase 0, once a byte completes, further clock edges are ignored until select has risen and fallen again. They produce no `rxDone`.
- R6: With phase 1, the first edge of each byte loads `txByte`, the output advances on odd edges and data is sampled on even edges. Bytes may follow back to back without releasing select.
- R7: `cfgPol` = 0 means the clock idles low, and 1 means it idles high. Odd edges are those leaving the idle level. Both settings transfer correctly.
- R8: After the last sample edge, `rxByte` takes the received byte and `rxDone` is high for exactly one cycle. `rxByte` holds its value until the next completed byte.
- R9: If select rises before a byte is complete, no `rxDone` is produced. The next frame starts again at its first bit.
- R10: After reset, `rxDone` = 0, `rxByte` = 0 and `misoOe` = 0.
- R11: The serial clock must run no faster than one quarter of the system clock. All serial inputs are synchronised with SYNC_STAGES (2) flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from the master |
| mosiIn | input | 1 | Serial data from the master |
| selN | input | 1 | Active-low slave select |
| cfgPol | input | 1 | Clock idle level (0 low, 1 high) |
| cfgPha | input | 1 | Clock phase mode (0 or 1) |
| txByte | input | DATA_W | Byte to send to the master |
| misoOut | output | 1 | Serial data to the master (pad data) |
| misoOe | output | 1 | Pad drive enable for misoOut |
| rxByte | output | DATA_W | Last received byte |
| rxDone | output | 1 | One-cycle byte-complete strobe |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 2. It drives a serial clock of one sixteenth of the system rate, which leaves eight system cycles per half period. That margin covers the synchroniser and edge-detect latency, so the bench can sample the slave output at each master capture edge. With these values all four polarity/phase combinations are reachable, together with back-to-back phase-1 bytes, the phase-0 select-toggle rule and mid-byte aborts, each in a few hundred cycles.

// File: rtl/spi_shift_slave_pkg.sv
package spi_shift_slave_pkg;

  // Strobes from control to datapath, valid for one system cycle.
  typedef struct packed {
    logic load;      // copy txByte into the transmit shifter
    logic shiftTx;   // advance the transmit shifter by one bit
    logic sampleRx;  // shift the synchronised data bit into the receive shifter
    logic commit;    // byte complete: publish the received byte
  } spiStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_HOLD   = 2'd2
  } frameState_t;

endpackage

// File: rtl/spi_shift_slave_sync.sv
module spi_shift_slave_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RESET_VAL;
        else       chain[s] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RESET_VAL;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/spi_shift_slave_ctrl.sv
module spi_shift_slave_ctrl
  import spi_shift_slave_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       mosiIn,
  input  logic       selN,
  input  logic       cfgPol,
  input  logic       cfgPha,
  output spiStrobe_t strobe,
  output logic       mosiBit,
  output logic       driveEn
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic selS, sclkS, mosiS;
  logic prevSclk, prevSel;
  frameState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;

  spi_shift_slave_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(3'b100)
  ) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din ({selN, sclkIn, mosiIn}),
    .dout({selS, sclkS, mosiS})
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSclk <= 1'b0;
      prevSel  <= 1'b1;
      state    <= ST_IDLE;
      bitCnt   <= '0;
    end else begin
      prevSclk <= sclkS;
      prevSel  <= selS;
      state    <= stateNxt;
      bitCnt   <= bitCntNxt;
    end
  end

  logic toggled, leadEdge, trailEdge, sampleEdge, shiftEdge, selFall, lastBit;

  always_comb begin
    toggled    = sclkS ^ prevSclk;
    leadEdge   = toggled & (sclkS != cfgPol);   // leaves idle level: odd edge
    trailEdge  = toggled & (sclkS == cfgPol);   // returns to idle: even edge
    sampleEdge = cfgPha ? trailEdge : leadEdge;
    shiftEdge  = cfgPha ? leadEdge : trailEdge;
    selFall    = prevSel & ~selS;
    lastBit    = (bitCnt == LAST_BIT);
  end

  always_comb begin
    strobe    = '0;
    stateNxt  = state;
    bitCntNxt = bitCnt;
    if (selS) begin
      stateNxt  = ST_IDLE;
      bitCntNxt = '0;
    end else if (selFall) begin
      strobe.load = 1'b1;
      stateNxt    = ST_ACTIVE;
      bitCntNxt   = '0;
    end else if (state == ST_ACTIVE) begin
      if (sampleEdge) begin
        strobe.sampleRx = 1'b1;
        if (lastBit) begin
          strobe.commit = 1'b1;
          bitCntNxt     = '0;
          if (!cfgPha) stateNxt = ST_HOLD;
        end else begin
          bitCntNxt = bitCnt + 1'b1;
        end
      end
      if (shiftEdge) begin
        if (cfgPha && bitCnt == '0) strobe.load    = 1'b1;
        else                        strobe.shiftTx = 1'b1;
      end
    end
  end

  assign mosiBit = mosiS;
  assign driveEn = ~selS;

endmodule

// File: rtl/spi_shift_slave_dpath.sv
module spi_shift_slave_dpath
  import spi_shift_slave_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        strobe,
  input  logic              mosiBit,
  input  logic [DATA_W-1:0] txByte,
  output logic              misoOut,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxDone
);

  logic [DATA_W-1:0] txShift, rxShift, rxNext;

  assign rxNext = {rxShift[DATA_W-2:0], mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.load || strobe.commit) begin
      txShift <= txByte;
    end else if (strobe.shiftTx) begin
      txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxByte  <= '0;
      rxDone  <= 1'b0;
    end else begin
      rxDone <= strobe.commit;
      if (strobe.sampleRx) rxShift <= rxNext;
      if (strobe.commit)   rxByte  <= rxNext;
    end
  end

  assign misoOut = txShift[DATA_W-1];

endmodule

// File: rtl/spi_shift_slave.sv
module spi_shift_slave
  import spi_shift_slave_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              mosiIn,
  input  logic              selN,
  input  logic              cfgPol,
  input  logic              cfgPha,
  input  logic [DATA_W-1:0] txByte,
  output logic              misoOut,
  output logic              misoOe,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxDone
);

  spiStrobe_t strobe;
  logic mosiBit;

  spi_shift_slave_ctrl #(
    .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclkIn (sclkIn),
    .mosiIn (mosiIn),
    .selN   (selN),
    .cfgPol (cfgPol),
    .cfgPha (cfgPha),
    .strobe (strobe),
    .mosiBit(mosiBit),
    .driveEn(misoOe)
  );

  spi_shift_slave_dpath #(
    .DATA_W(DATA_W)
  ) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .mosiBit(mosiBit),
    .txByte (txByte),
    .misoOut(misoOut),
    .rxByte (rxByte),
    .rxDone (rxDone)
  );

endmodule

// File: rtl/spi_shift_slave_chk.sv
module spi_shift_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              selN,
  input logic              misoOe,
  input logic              rxDone,
  input logic [DATA_W-1:0] rxByte
);

  // R8
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  // R8
  rxbyte_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxDone |-> $stable(rxByte));

  // R2
  oe_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(selN, 1) && $past(selN, 2) && $past(selN, 3)) |-> !misoOe);

  // R9
  no_done_deselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(selN, 1) && $past(selN, 2) && $past(selN, 3) && $past(selN, 4)) |-> !rxDone);

  // R2
  oe_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(selN, 1) && !$past(selN, 2) && !$past(selN, 3)) |-> misoOe);

endmodule

bind spi_shift_slave spi_shift_slave_chk #(.DATA_W(DATA_W)) chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .selN  (selN),
  .misoOe(misoOe),
  .rxDone(rxDone),
  .rxByte(rxByte)
);

// File: tb/spi_shift_slave_tb_top.sv
`timescale 1ns/1ps
module spi_shift_slave_tb_top;

  localparam int HP = 8;   // system cycles per serial half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, mosiIn = 1'b0, selN = 1'b1, cfgPol = 1'b0, cfgPha = 1'b0;
  logic [7:0] txByte = '0;
  logic misoOut, misoOe, rxDone;
  logic [7:0] rxByte;

  int errors = 0;
  int checks = 0;
  int doneCnt = 0;
  int expDone = 0;
  bit finished = 0;
  logic [7:0] sbQ[$];

  always #2 clk = ~clk;   // 250 MHz

  spi_shift_slave dut_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .mosiIn(mosiIn), .selN(selN),
    .cfgPol(cfgPol), .cfgPha(cfgPha), .txByte(txByte),
    .misoOut(misoOut), .misoOe(misoOe), .rxByte(rxByte), .rxDone(rxDone)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: plays the master and pushes the expected received byte.
  task automatic xfer(input logic pol, input logic pha, input logic [7:0] m,
                      input logic [7:0] s, input int nbits, input bit keepSel);
    logic [7:0] cap = '0;
    if (selN) begin
      cfgPol = pol; cfgPha = pha; sclkIn = pol;
    end
    txByte = s;
    if (nbits == 8) begin
      sbQ.push_back(m);
      expDone++;
    end
    if (selN) begin
      waitClk(HP);
      selN = 1'b0;
    end
    waitClk(HP);
    check(misoOe == 1'b1, "R2 drive enable while selected", misoOe, 1);
    for (int i = 0; i < nbits; i++) begin
      if (!pha) begin
        mosiIn = m[7-i];
        waitClk(HP);
        cap = {cap[6:0], misoOut};   // R4: master captures on odd edge
        sclkIn = ~pol;
        waitClk(HP);
        sclkIn = pol;
      end else begin
        sclkIn = ~pol;               // R6: odd edge advances data
        mosiIn = m[7-i];
        waitClk(HP);
        cap = {cap[6:0], misoOut};
        sclkIn = pol;
        waitClk(HP);
      end
    end
    if (nbits == 8)
      check(cap == s, pha ? "R6 R7 R1 slave byte" : "R3 R4 R7 R1 slave byte", cap, s);
    if (!keepSel) begin
      waitClk(HP);
      selN = 1'b1;
      waitClk(HP);
    end
  endtask

  // Monitor: pops the scoreboard on every completion strobe.
  always @(negedge clk) begin
    if (rstN && rxDone && !finished) begin
      doneCnt++;
      if (sbQ.size() == 0) begin
        check(1'b0, "R5 R9 unexpected rxDone", rxByte, 0);
      end else begin
        automatic logic [7:0] e = sbQ.pop_front();
        check(rxByte == e, "R1 R8 received byte", rxByte, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    // R10
    check(rxDone == 1'b0, "R10 rxDone reset", rxDone, 0);
    check(rxByte == 8'h00, "R10 rxByte reset", rxByte, 0);
    check(misoOe == 1'b0, "R10 misoOe reset", misoOe, 0);
    rstN = 1'b1;
    waitClk(5);
    check(misoOe == 1'b0, "R2 idle enable low", misoOe, 0);

    // R7 all four modes, R11 at 1/16 of system clock
    xfer(1'b0, 1'b0, 8'hA5, 8'h3C, 8, 1'b0);
    xfer(1'b1, 1'b0, 8'h81, 8'h7E, 8, 1'b0);
    xfer(1'b0, 1'b1, 8'h5A, 8'hC3, 8, 1'b0);
    xfer(1'b1, 1'b1, 8'h01, 8'h80, 8, 1'b0);
    check(misoOe == 1'b0, "R2 enable released", misoOe, 0);
    check(rxByte == 8'h01, "R8 rxByte holds", rxByte, 8'h01);

    // R6 back-to-back bytes without releasing select
    xfer(1'b0, 1'b1, 8'hF0, 8'h0F, 8, 1'b1);
    xfer(1'b0, 1'b1, 8'h96, 8'h69, 8, 1'b0);

    // R5 phase 0: extra clocks after a byte with select low are ignored
    xfer(1'b0, 1'b0, 8'hC6, 8'h6C, 8, 1'b1);
    for (int i = 0; i < 8; i++) begin
      mosiIn = i[0];
      waitClk(HP); sclkIn = 1'b1;
      waitClk(HP); sclkIn = 1'b0;
    end
    waitClk(HP);
    selN = 1'b1;
    waitClk(HP);
    check(doneCnt == expDone, "R5 no strobe without select toggle", doneCnt, expDone);

    // R9 abort mid-byte, then a clean byte
    xfer(1'b1, 1'b0, 8'hFF, 8'h00, 4, 1'b0);
    check(doneCnt == expDone, "R9 no strobe on abort", doneCnt, expDone);
    xfer(1'b1, 1'b0, 8'h2D, 8'hD2, 8, 1'b0);
    xfer(1'b0, 1'b1, 8'hFF, 8'hFF, 3, 1'b0);
    xfer(1'b0, 1'b1, 8'h00, 8'h55, 8, 1'b0);

    waitClk(20);
    check(doneCnt == expDone, "R8 strobe count", doneCnt, expDone);
    check(sbQ.size() == 0, "R8 scoreboard drained", sbQ.size(), 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule